// File: doc/BRIEF.md
# Link status and activity indicator unit

This unit sits beside the two data paths of a 100 Mb/s converter that has a twisted-pair side and a fiber side, and runs on the 25 MHz symbol clock. For each side it takes a link-good level, a receive-activity pulse and a code-error pulse, all already qualified and synchronous to the symbol clock. From these it drives six active-low indicator outputs: link, receive and error for each side.

The unit also owns the last stage of each transmit path. When the opposite side has link, the 5-bit symbol relayed toward a side passes through. When the opposite side has no link, a fill symbol goes out in its place. A static strap selects the fill symbol. Halt carries the loss of link on to the far partner. Idle hides it.

While reset is held, every indicator is lit, which serves as a lamp test.

Top module: `link_led_unit`

## Requirements
- R1: While the opposite side's link is high at a clock edge, the symbol output toward a side equals the relayed symbol input sampled at that edge, so it is one clock late.
- R2: When the opposite side's link is low at a clock edge, the symbol output toward a side shows the fill symbol from that edge on. The fiber link gates the twisted-pair output and the twisted-pair link gates the fiber output.
- R3: The fill symbol is Halt, 5'b00100, when the halt strap is 1, and Idle, 5'b11111, when the strap is 0.
- R4: The first edge that samples the opposite link high releases the fill, and relayed symbols resume from that edge.
- R5: A link indicator is low (lit) in the same cycle that its side's link input is high, and high (dark) while the link input is low.
- R6: A receive-activity pulse sampled at an edge lights that side's receive indicator from that edge for exactly STRETCH_CYC clocks. It then goes dark unless a new pulse arrives.
- R7: A new event while an indicator is stretched restarts the full STRETCH_CYC interval from the new event's edge.
- R8: A code-error pulse drives that side's error indicator with the same stretch and restart rule as R6 and R7.
- R9: While rst_ni is low, all six indicators are low (lit) and both symbol outputs are Idle, 5'b11111.
- R10: After reset, the receive and error indicators stay dark until an event arrives.
- R11: The two sides are independent. Events and link on one side change only that side's indicators and only the symbol output toward the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 25 MHz symbol clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_fill_i | input | 1 | Static strap: 1 selects Halt as the fill symbol, 0 selects Idle |
| tp_link_i | input | 1 | Twisted-pair link good |
| tp_rx_act_i | input | 1 | Twisted-pair receive-activity pulse |
| tp_code_err_i | input | 1 | Twisted-pair code-error pulse |
| fx_link_i | input | 1 | Fiber link good |
| fx_rx_act_i | input | 1 | Fiber receive-activity pulse |
| fx_code_err_i | input | 1 | Fiber code-error pulse |
| tp_sym_i | input | 5 | Symbol relayed toward the twisted-pair transmitter |
| fx_sym_i | input | 5 | Symbol relayed toward the fiber transmitter |
| tp_sym_o | output | 5 | Symbol to the twisted-pair transmitter |
| fx_sym_o | output | 5 | Symbol to the fiber transmitter |
| tp_link_led_no | output | 1 | Twisted-pair link indicator, active low |
| tp_rx_led_no | output | 1 | Twisted-pair receive indicator, active low |
| tp_err_led_no | output | 1 | Twisted-pair error indicator, active low |
| fx_link_led_no | output | 1 | Fiber link indicator, active low |
| fx_rx_led_no | output | 1 | Fiber receive indicator, active low |
| fx_err_led_no | output | 1 | Fiber error indicator, active low |

## Verification
A stretch counter that is off by one, or that fails to reload, shows up first at an indicator. The indicator goes dark one clock early or late, or it ignores a retrigger. This is visible on the first event, no more than STRETCH_CYC clocks later. A swapped link gate, or a fill register that holds a stale value, corrupts a symbol output on the first edge after a link change. The halt strap has the same effect on the first fill cycle. The bench shortens the stretch so that every boundary can be reached, and it compares all eight outputs against a model on every cycle.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;
  localparam int NSIDE = 2;  // 0: twisted pair, 1: fiber
  typedef logic [4:0] sym_t;
  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_HALT = 5'b00100;

  function automatic sym_t fill_sym(input logic halt);
    return halt ? SYM_HALT : SYM_IDLE;
  endfunction
endpackage

// File: rtl/pulse_stretch.sv
module pulse_stretch #(
  parameter int STRETCH_CYC = 1_250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  output logic lit_o
);
  localparam int CW = $clog2(STRETCH_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (ev_i)        cnt_q <= LOAD;   // retrigger restarts
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign lit_o = (cnt_q != '0);

  p_lit_after_event_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i |=> lit_o);
  p_no_spurious_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lit_o && !ev_i) |=> !lit_o);
  p_decay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lit_o && !ev_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fill_mux.sv
module fill_mux
  import lnkmon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic peer_link_i,
  input  sym_t data_i,
  output sym_t sym_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sym_o <= SYM_IDLE;
    else if (peer_link_i) sym_o <= data_i;
    else                  sym_o <= fill_sym(halt_i);
  end

  p_relay_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peer_link_i |=> (sym_o == $past(data_i)));
  p_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !peer_link_i |=> (sym_o == ($past(halt_i) ? SYM_HALT : SYM_IDLE)));
endmodule

// File: rtl/link_led_unit.sv
module link_led_unit
  import lnkmon_pkg::*;
#(
  parameter int STRETCH_CYC = 1_250_000  // about 50 ms at 25 MHz
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_fill_i,
  input  logic       tp_link_i,
  input  logic       tp_rx_act_i,
  input  logic       tp_code_err_i,
  input  logic       fx_link_i,
  input  logic       fx_rx_act_i,
  input  logic       fx_code_err_i,
  input  logic [4:0] tp_sym_i,
  input  logic [4:0] fx_sym_i,
  output logic [4:0] tp_sym_o,
  output logic [4:0] fx_sym_o,
  output logic       tp_link_led_no,
  output logic       tp_rx_led_no,
  output logic       tp_err_led_no,
  output logic       fx_link_led_no,
  output logic       fx_rx_led_no,
  output logic       fx_err_led_no
);
  logic [NSIDE-1:0] link, rx_ev, err_ev, rx_lit, err_lit;
  sym_t             sym_in [NSIDE];
  sym_t             sym_out[NSIDE];

  assign link   = {fx_link_i, tp_link_i};
  assign rx_ev  = {fx_rx_act_i, tp_rx_act_i};
  assign err_ev = {fx_code_err_i, tp_code_err_i};
  assign sym_in[0] = tp_sym_i;
  assign sym_in[1] = fx_sym_i;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    // symbol toward side s is gated by the opposite side's link
    fill_mux u_fill (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .halt_i      (halt_fill_i),
      .peer_link_i (link[NSIDE-1-s]),
      .data_i      (sym_in[s]),
      .sym_o       (sym_out[s])
    );
    pulse_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_rx (
      .clk_i (clk_i), .rst_ni (rst_ni), .ev_i (rx_ev[s]), .lit_o (rx_lit[s])
    );
    pulse_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_err (
      .clk_i (clk_i), .rst_ni (rst_ni), .ev_i (err_ev[s]), .lit_o (err_lit[s])
    );
  end

  assign tp_sym_o = sym_out[0];
  assign fx_sym_o = sym_out[1];

  // lamp test: reset low lights every LED
  assign tp_link_led_no = rst_ni & ~link[0];
  assign fx_link_led_no = rst_ni & ~link[1];
  assign tp_rx_led_no   = rst_ni & ~rx_lit[0];
  assign fx_rx_led_no   = rst_ni & ~rx_lit[1];
  assign tp_err_led_no  = rst_ni & ~err_lit[0];
  assign fx_err_led_no  = rst_ni & ~err_lit[1];

  p_rx_led_follow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tp_rx_act_i |=> !tp_rx_led_no);
  p_err_led_follow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx_code_err_i |=> !fx_err_led_no);
endmodule

// File: tb/sim_link_led_unit.sv
module sim_link_led_unit;
  localparam int CLK_PERIOD = 40;
  localparam int ST = 6;
  localparam logic [4:0] IDLE = 5'b11111;
  localparam logic [4:0] HALT = 5'b00100;

  logic clk = 0, rst_n = 0, halt = 0;
  logic [1:0] link = 0, rx = 0, err = 0;
  logic [4:0] din [2];
  logic [4:0] sym [2];
  logic [1:0] lnk_led, rx_led, err_led;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [4:0] e_sym [2];
  int e_rx [2];
  int e_err [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  link_led_unit #(.STRETCH_CYC(ST)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .halt_fill_i(halt),
    .tp_link_i(link[0]), .tp_rx_act_i(rx[0]), .tp_code_err_i(err[0]),
    .fx_link_i(link[1]), .fx_rx_act_i(rx[1]), .fx_code_err_i(err[1]),
    .tp_sym_i(din[0]), .fx_sym_i(din[1]),
    .tp_sym_o(sym[0]), .fx_sym_o(sym[1]),
    .tp_link_led_no(lnk_led[0]), .tp_rx_led_no(rx_led[0]), .tp_err_led_no(err_led[0]),
    .fx_link_led_no(lnk_led[1]), .fx_rx_led_no(rx_led[1]), .fx_err_led_no(err_led[1])
  );

  function automatic logic [4:0] fill(input logic h);
    return h ? HALT : IDLE;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < 2; s++) begin
      e_sym[s] = IDLE; e_rx[s] = 0; e_err[s] = 0;
    end
  endtask

  task automatic compare(input string tag);
    for (int s = 0; s < 2; s++) begin
      chk(tag, s ? "fx sym" : "tp sym", sym[s], e_sym[s]);
      chk(tag, s ? "fx link led" : "tp link led", lnk_led[s], rst_n & ~link[s]);
      chk(tag, s ? "fx rx led" : "tp rx led", rx_led[s], rst_n & (e_rx[s] == 0));
      chk(tag, s ? "fx err led" : "tp err led", err_led[s], rst_n & (e_err[s] == 0));
    end
  endtask

  // one clock: model follows inputs sampled at the edge, compare at negedge
  task automatic tick(input string tag);
    @(posedge clk);
    if (rst_n) begin
      for (int s = 0; s < 2; s++) begin
        e_sym[s] = link[1-s] ? din[s] : fill(halt);
        e_rx[s]  = rx[s]  ? ST : (e_rx[s]  > 0 ? e_rx[s]  - 1 : 0);
        e_err[s] = err[s] ? ST : (e_err[s] > 0 ? e_err[s] - 1 : 0);
      end
    end
    @(negedge clk);
    compare(tag);
    rx = 0; err = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; model_reset();
    #1 compare("R9");
    for (int i = 0; i < 3; i++) tick("R9");
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    din[0] = 5'h0a; din[1] = 5'h15;
    model_reset();
    link = 2'b11;
    @(negedge clk);
    do_reset();
    // R10: dark after reset with no events
    for (int i = 0; i < 4; i++) tick("R10");
    // R1: relay with both links up
    for (int i = 0; i < 4; i++) begin
      din[0] = 5'(i * 3); din[1] = 5'(31 - i);
      tick("R1");
    end
    // R6: single pulse, stretch boundary
    rx[0] = 1;
    for (int i = 0; i < ST + 3; i++) tick("R6");
    // R7: retrigger mid-stretch
    rx[1] = 1; tick("R7");
    for (int i = 0; i < 3; i++) tick("R7");
    rx[1] = 1;
    for (int i = 0; i < ST + 2; i++) tick("R7");
    // R8: error stretch
    err[0] = 1; tick("R8");
    err[1] = 1;
    for (int i = 0; i < ST + 2; i++) tick("R8");
    // R2/R3: fiber link drop, halt fill
    halt = 1; link[1] = 0;
    for (int i = 0; i < 3; i++) tick("R3");
    halt = 0;
    for (int i = 0; i < 2; i++) tick("R2");
    // R4: release
    link[1] = 1; din[0] = 5'h07;
    for (int i = 0; i < 2; i++) tick("R4");
    // R5: link LEDs follow link inputs
    link = 2'b01; tick("R5");
    link = 2'b10; tick("R5");
    link = 2'b11; tick("R5");
    // R9: lamp test mid-run, with counters running
    rx = 2'b11; err = 2'b11; tick("R9");
    do_reset();
    for (int i = 0; i < 3; i++) tick("R10");
    // R11: random mixed traffic
    for (int i = 0; i < 3000; i++) begin
      for (int s = 0; s < 2; s++) begin
        din[s] = 5'($urandom);
        rx[s]  = ($urandom % 12) == 0;
        err[s] = ($urandom % 20) == 0;
        if (($urandom % 40) == 0) link[s] = ~link[s];
      end
      if (($urandom % 300) == 0) halt = ~halt;
      tick("R11");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule